// File: doc/BRIEF.md
# Clock-Generator Configuration Register Slave (Block-Write I2C)

This block is an I2C slave that holds six 8-bit configuration registers for an on-chip clock generator. It decodes one 7-bit device address and accepts only block writes. After the address byte the host sends a command byte and a count byte, and the slave acknowledges both and throws both away. Every data byte after those two goes into the registers in sequence, starting at register 0 and acknowledged one byte at a time. The host may stop after any complete byte.

A block read returns a byte count first and then the registers from 0 upward. SCL and SDA come in as asynchronous levels and are oversampled by the system clock through a two-flop synchronizer. The slave drives the bus only through an open-drain pull-down enable. All register contents are available as one parallel bus for the clock-generator logic.

Top module: `i2cCfgSlave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0x69 (address byte 0xD2 to write, 0xD3 to read). Any other address gets no acknowledge, and the bytes that follow it in the same transfer are neither acknowledged nor stored.
- R2: On a write, the two bytes after the address (command, then count) are acknowledged and have no effect on any register.
- R3: Write data bytes are acknowledged one at a time and go to register 0, then 1, up to register 5. Register k sits at cfgRegs[8k+7:8k].
- R4: A stop after any complete data byte keeps the registers already written. Registers not reached keep their previous values.
- R5: A block read returns the byte count 0x06 first, then registers 0 to 5 in order, most significant bit first. The host acknowledges each byte by pulling SDA low.
- R6: Reset loads register 0 to 5 with 0x1E, 0xFF, 0xFF, 0x00, 0x00, 0x06, and the SDA pull-down is off.
- R7: Bits 7:4 of register 0 are read-only. A write changes only bits 3:0 of register 0.
- R8: Data bytes written beyond register 5 are acknowledged and discarded. A read that continues beyond register 5 returns 0xFF.
- R9: A repeated start in the middle of a transfer restarts the byte sequence, so the next write data byte goes to register 0 again.
- R10: A host NACK during a read ends the transfer: the slave releases SDA and drives nothing more until the next start.
- R11: The slave asserts its SDA pull-down only while the synchronized SCL is low, and SDA never changes during an SCL high phase of a read bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock level, asynchronous |
| sdaIn | input | 1 | Bus data level, asynchronous |
| sdaDriveLow | output | 1 | When high, the pad pulls SDA low |
| cfgRegs | output | 48 | Registers 0..5, register k at bits 8k+7:8k |

## Verification
The bench uses the default parameters: six registers, device address 0x69, only the upper nibble of register 0 read-only, and a read count equal to the register count. With these values an eight-byte write and an eight-byte read run past the last register, so the discard path and the 0xFF fill are both reached. The upper nibble 0x1 of the register 0 default also shows whether a write has leaked into the identification bits. With a bus bit of fifty system clocks, the synchronizer latency is small against the SCL low phase, so the slave's ack and data timing can be checked against a master that samples in the middle of each high phase.

// File: rtl/i2cCfgPkg.sv
package i2cCfgPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } busState_t;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic shiftIn;    // capture sampled SDA into the shift register
    logic ptrClr;     // address accepted: register pointer back to 0
    logic writeReg;   // commit received byte to the pointed register
    logic loadCount;  // load read byte count for transmission
    logic loadNext;   // load next register (or fill) for transmission
    logic shiftOut;   // advance transmit shift register by one bit
  } dpStrb_t;

endpackage

// File: rtl/i2cSync.sv
module i2cSync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[CHAIN_W-WIDTH-1:0], asyncIn};
  end

  assign syncOut = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/i2cCfgData.sv
module i2cCfgData
  import i2cCfgPkg::*;
#(
  parameter int                    NUM_REGS     = 6,
  parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = 48'h06_00_00_FF_FF_1E,
  parameter logic [NUM_REGS*8-1:0] RO_MASK      = 48'h00_00_00_00_00_F0,
  parameter logic [7:0]            COUNT_VALUE  = 8'd6
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrb_t               strb,
  input  logic                  sdaBit,
  output logic [7:0]            rxByte,
  output logic                  txBit,
  output logic [NUM_REGS*8-1:0] cfgRegs
);
  localparam int                PTR_W    = $clog2(NUM_REGS + 1);
  localparam logic [PTR_W-1:0]  LAST_PTR = PTR_W'(NUM_REGS);

  logic [7:0]            shiftReg;
  logic [PTR_W-1:0]      ptr;
  logic [NUM_REGS*8-1:0] regBus;
  logic                  ptrInRange;

  assign ptrInRange = (ptr < LAST_PTR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= 8'hFF;
    end else if (strb.shiftIn) begin
      shiftReg <= {shiftReg[6:0], sdaBit};
    end else if (strb.loadCount) begin
      shiftReg <= COUNT_VALUE;
    end else if (strb.loadNext) begin
      shiftReg <= ptrInRange ? regBus[ptr*8 +: 8] : 8'hFF;
    end else if (strb.shiftOut) begin
      shiftReg <= {shiftReg[6:0], 1'b1};
    end
  end

  // pointer saturates one past the last register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strb.ptrClr) begin
      ptr <= '0;
    end else if ((strb.writeReg || strb.loadNext) && ptrInRange) begin
      ptr <= ptr + PTR_W'(1);
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [7:0] DEF = REG_DEFAULTS[8*i +: 8];
    localparam logic [7:0] RO  = RO_MASK[8*i +: 8];
    logic [7:0] regQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ <= DEF;
      end else if (strb.writeReg && (ptr == PTR_W'(i))) begin
        regQ <= (regQ & RO) | (shiftReg & ~RO);
      end
    end

    assign regBus[8*i +: 8] = regQ;
  end

  assign rxByte  = shiftReg;
  assign txBit   = shiftReg[7];
  assign cfgRegs = regBus;
endmodule

// File: rtl/i2cCfgCtrl.sv
module i2cCfgCtrl
  import i2cCfgPkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclS,
  input  logic       sdaS,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output dpStrb_t    strb,
  output logic       sdaDriveLow
);
  localparam logic [3:0] BYTE_BITS = 4'd8;
  localparam logic [1:0] DATA_IDX  = 2'd2;

  busState_t  state, stateN;
  logic [3:0] bitCnt, bitCntN;
  logic [1:0] byteIdx, byteIdxN;
  logic       ackDrive, ackN;
  logic       nackSeen, nackN;
  logic       sclD, sdaD;
  logic       sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclD <= sclS;
      sdaD <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

  always_comb begin
    stateN   = state;
    bitCntN  = bitCnt;
    byteIdxN = byteIdx;
    ackN     = ackDrive;
    nackN    = nackSeen;
    strb     = '0;
    if (startDet) begin
      stateN  = ST_ADDR;
      bitCntN = '0;
      ackN    = 1'b0;
    end else if (stopDet) begin
      stateN = ST_IDLE;
      ackN   = 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WR_BYTE: begin
          if (sclRise && (bitCnt < BYTE_BITS)) begin
            strb.shiftIn = 1'b1;
            bitCntN      = bitCnt + 4'd1;
          end else if (sclFall && (bitCnt == BYTE_BITS)) begin
            if (state == ST_ADDR) begin
              if (rxByte[7:1] == DEV_ADDR) begin
                stateN      = ST_ADDR_ACK;
                ackN        = 1'b1;
                strb.ptrClr = 1'b1;
                byteIdxN    = '0;
              end else begin
                stateN = ST_IDLE;
              end
            end else begin
              stateN        = ST_WR_ACK;
              ackN          = 1'b1;
              strb.writeReg = (byteIdx == DATA_IDX);
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            ackN    = 1'b0;
            bitCntN = '0;
            if (rxByte[0]) begin
              stateN         = ST_RD_BYTE;
              strb.loadCount = 1'b1;
            end else begin
              stateN = ST_WR_BYTE;
            end
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            ackN    = 1'b0;
            bitCntN = '0;
            stateN  = ST_WR_BYTE;
            if (byteIdx != DATA_IDX) byteIdxN = byteIdx + 2'd1;
          end
        end
        ST_RD_BYTE: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              stateN = ST_RD_ACK;
              nackN  = 1'b0;
            end else begin
              strb.shiftOut = 1'b1;
              bitCntN       = bitCnt + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) begin
            nackN = sdaS;
          end else if (sclFall) begin
            if (nackSeen) begin
              stateN = ST_IDLE;
            end else begin
              stateN        = ST_RD_BYTE;
              strb.loadNext = 1'b1;
              bitCntN       = '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      byteIdx  <= '0;
      ackDrive <= 1'b0;
      nackSeen <= 1'b0;
    end else begin
      state    <= stateN;
      bitCnt   <= bitCntN;
      byteIdx  <= byteIdxN;
      ackDrive <= ackN;
      nackSeen <= nackN;
    end
  end

  assign sdaDriveLow = ackDrive | ((state == ST_RD_BYTE) & ~txBit);
endmodule

// File: rtl/i2cCfgSlave.sv
module i2cCfgSlave
  import i2cCfgPkg::*;
#(
  parameter int                    NUM_REGS     = 6,
  parameter logic [6:0]            DEV_ADDR     = 7'h69,
  parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = 48'h06_00_00_FF_FF_1E,
  parameter logic [NUM_REGS*8-1:0] RO_MASK      = 48'h00_00_00_00_00_F0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaDriveLow,
  output logic [NUM_REGS*8-1:0] cfgRegs
);
  localparam logic [7:0] COUNT_VALUE = 8'(NUM_REGS);

  logic       sclS, sdaS, txBit;
  logic [7:0] rxByte;
  dpStrb_t    strb;

  i2cSync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({sclIn, sdaIn}),
    .syncOut ({sclS, sdaS})
  );

  i2cCfgCtrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .sclS        (sclS),
    .sdaS        (sdaS),
    .rxByte      (rxByte),
    .txBit       (txBit),
    .strb        (strb),
    .sdaDriveLow (sdaDriveLow)
  );

  i2cCfgData #(
    .NUM_REGS     (NUM_REGS),
    .REG_DEFAULTS (REG_DEFAULTS),
    .RO_MASK      (RO_MASK),
    .COUNT_VALUE  (COUNT_VALUE)
  ) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .sdaBit  (sdaS),
    .rxByte  (rxByte),
    .txBit   (txBit),
    .cfgRegs (cfgRegs)
  );
endmodule

// File: rtl/i2cCfgSlaveChk.sv
module i2cCfgSlaveChk #(
  parameter int                    NUM_REGS     = 6,
  parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = 48'h06_00_00_FF_FF_1E,
  parameter logic [NUM_REGS*8-1:0] RO_MASK      = 48'h00_00_00_00_00_F0
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sclSync,
  input logic                  sdaDriveLow,
  input logic [NUM_REGS*8-1:0] cfgRegs
);
  // R6: first cycle out of reset shows the default register image
  a_r6_reset_defaults: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (cfgRegs == REG_DEFAULTS));

  // R7: read-only bits never move
  a_r7_id_bits_hold: assert property (@(posedge clk) disable iff (!rstN)
    $stable(cfgRegs & RO_MASK));

  // R3: a register only changes in the cycle the slave starts its acknowledge
  a_r3_write_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgRegs) |-> sdaDriveLow);

  // R11: pulling SDA low begins only while SCL is low
  a_r11_pull_in_low_phase: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclSync);
endmodule

bind i2cCfgSlave i2cCfgSlaveChk #(
  .NUM_REGS     (NUM_REGS),
  .REG_DEFAULTS (REG_DEFAULTS),
  .RO_MASK      (RO_MASK)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .sclSync     (sclS),
  .sdaDriveLow (sdaDriveLow),
  .cfgRegs     (cfgRegs)
);

// File: tb/test_i2cCfgSlave.sv
module test_i2cCfgSlave;
  localparam int Q = 12;
  // entry: [67:64] data byte count, [63:56] command, [55:48] count byte, [47:0] data (byte 0 low)
  localparam logic [67:0] WR_VEC [4] = '{
    {4'd6, 8'h00, 8'h06, 48'h9A_78_56_34_12_A3},
    {4'd2, 8'h5C, 8'hC5, 48'h00_00_00_00_81_0C},
    {4'd0, 8'hFF, 8'hFF, 48'h11_22_33_44_55_66},
    {4'd8, 8'h3E, 8'h08, 48'hC3_3C_F0_0F_AA_55}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN = 1'b0;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic        sdaLine;
  logic        sdaDriveLow;
  logic [47:0] cfgRegs;

  int   nChecks = 0;
  int   nFail   = 0;
  bit   glitchSeen = 1'b0;
  bit   done = 1'b0;
  logic [7:0] model [6];

  assign sdaLine = sdaM & ~sdaDriveLow;

  i2cCfgSlave i_i2cCfgSlave (
    .clk         (clk),
    .rstN        (rstN),
    .sclIn       (sclM),
    .sdaIn       (sdaLine),
    .sdaDriveLow (sdaDriveLow),
    .cfgRegs     (cfgRegs)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string msg, input logic [47:0] act, input logic [47:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", msg, act, exp);
    end
  endtask

  function automatic logic [47:0] modelBus();
    return {model[5], model[4], model[3], model[2], model[1], model[0]};
  endfunction

  task automatic resetModel();
    model[0] = 8'h1E; model[1] = 8'hFF; model[2] = 8'hFF;
    model[3] = 8'h00; model[4] = 8'h00; model[5] = 8'h06;
  endtask

  task automatic modelWrite(input int idx, input logic [7:0] d);
    if (idx == 0)     model[0] = (model[0] & 8'hF0) | (d & 8'h0F);
    else if (idx < 6) model[idx] = d;
  endtask

  task automatic sendBit(input logic b);
    tick(Q); sdaM = b; tick(Q); sclM = 1'b1; tick(2*Q); sclM = 1'b0;
  endtask

  task automatic readBit(output logic b);
    tick(Q); sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q);
    b = sdaLine;
    tick(Q - 2);
    if (sdaLine !== b) glitchSeen = 1'b1;
    tick(2); sclM = 1'b0;
  endtask

  task automatic busStart();
    tick(Q); sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(2*Q);
    sdaM = 1'b0; tick(2*Q); sclM = 1'b0;
  endtask

  task automatic busStop();
    tick(Q); sdaM = 1'b0; tick(Q); sclM = 1'b1; tick(2*Q);
    sdaM = 1'b1; tick(2*Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) sendBit(b[i]);
    readBit(a);
    acked = ~a;
  endtask

  task automatic recvByte(output logic [7:0] b, input logic ackIt);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      readBit(x);
      b[i] = x;
    end
    sendBit(~ackIt);
  endtask

  task automatic doWrite(input int n, input logic [7:0] cmd, input logic [7:0] cnt,
                         input logic [47:0] data);
    logic a;
    logic [7:0] d;
    busStart();
    sendByte(8'hD2, a);  check("R1 write address acknowledged", 48'(a), 48'd1);
    sendByte(cmd, a);    check("R2 command byte acknowledged", 48'(a), 48'd1);
    sendByte(cnt, a);    check("R2 count byte acknowledged", 48'(a), 48'd1);
    for (int i = 0; i < n; i++) begin
      d = (i < 6) ? data[8*i +: 8] : 8'hA5;
      sendByte(d, a);
      check((i < 6) ? "R3 data byte acknowledged" : "R8 extra byte acknowledged",
            48'(a), 48'd1);
      modelWrite(i, d);
    end
    busStop();
  endtask

  task automatic doRead(input int n);
    logic a;
    logic [7:0] b;
    busStart();
    sendByte(8'hD3, a);  check("R1 read address acknowledged", 48'(a), 48'd1);
    recvByte(b, 1'b1);   check("R5 byte count", 48'(b), 48'h06);
    for (int i = 0; i < n; i++) begin
      recvByte(b, i != n - 1);
      if (i < 6) check("R5 register read in order", 48'(b), 48'(model[i]));
      else       check("R8 read past last register", 48'(b), 48'hFF);
    end
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] b;
    resetModel();
    tick(5);
    check("R6 reset register image", cfgRegs, 48'h06_00_00_FF_FF_1E);
    check("R6 SDA released in reset", 48'(sdaDriveLow), 48'd0);
    rstN = 1'b1;
    tick(5);

    // table walk: R2 R3 R4 R7 R8 through varied writes, each read back (R5)
    for (int e = 0; e < 4; e++) begin
      doWrite(int'(WR_VEC[e][67:64]), WR_VEC[e][63:56], WR_VEC[e][55:48], WR_VEC[e][47:0]);
      tick(5);
      check($sformatf("R2 R3 R4 register image after entry %0d", e), cfgRegs, modelBus());
      if (e == 0) check("R7 id nibble kept on write", 48'(cfgRegs[7:0]), 48'h13);
      doRead(6);
    end

    // R1: foreign address gets no ack, following byte ignored
    busStart();
    sendByte(8'hA0, a);  check("R1 foreign address not acknowledged", 48'(a), 48'd0);
    sendByte(8'h00, a);  check("R1 byte after foreign address ignored", 48'(a), 48'd0);
    busStop();
    check("R1 registers untouched by foreign address", cfgRegs, modelBus());

    // R8: read beyond last register
    doRead(8);

    // R10: NACK mid-read releases SDA
    busStart();
    sendByte(8'hD3, a);
    recvByte(b, 1'b1);
    recvByte(b, 1'b0);   check("R10 byte before host NACK", 48'(b), 48'(model[0]));
    for (int i = 7; i >= 0; i--) begin
      logic x;
      readBit(x);
      b[i] = x;
    end
    check("R10 bus released after NACK", 48'(b), 48'hFF);
    check("R10 pull-down off after NACK", 48'(sdaDriveLow), 48'd0);
    busStop();

    // R9: repeated start restarts sequence at register 0
    busStart();
    sendByte(8'hD2, a); sendByte(8'h01, a); sendByte(8'h02, a);
    sendByte(8'h11, a); modelWrite(0, 8'h11);
    busStart();
    sendByte(8'hD2, a); sendByte(8'h01, a); sendByte(8'h02, a);
    sendByte(8'h77, a); modelWrite(0, 8'h77);
    busStop();
    tick(5);
    check("R9 repeated start writes register 0 again", cfgRegs, modelBus());

    // R6: reset in mid-run restores defaults
    rstN = 1'b0;
    tick(3);
    resetModel();
    check("R6 reset restores defaults", cfgRegs, modelBus());
    rstN = 1'b1;
    tick(5);

    check("R11 SDA stable through every SCL high phase", 48'(glitchSeen), 48'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule